// File: doc/BRIEF.md
# Longest Prefix Match Lookup Engine

This block is the route lookup stage of an IPv4 forwarding path. It keeps a small table of routes. Each route has a valid bit, a 32-bit prefix value, a prefix length from 0 to 32, and an outgoing port number. A destination address enters on a valid/ready interface. The engine compares the address against every route at once, each under the mask its own length gives. It then reports the port of the most specific matching route, together with a hit flag.

Routes are loaded and changed through a single-entry write port. Each write sets one entry's valid bit, prefix, length and port. The lookup path is pipelined so that it takes a new address on every clock once reset is released. Each answer appears two cycles after its address is accepted, and answers come out in the order the addresses went in.

Top module: `lpm_lookup_engine`

## Requirements
- R1: An entry of length L matches an address when the top L bits of the address equal the top L bits of the entry's prefix. For example, 65.0.0.0/8 covers 65.0.0.0 to 65.255.255.255, and a /32 entry covers only its own address.
- R2: A valid entry of length 0 matches every address and so acts as the default route.
- R3: When several valid entries of different lengths match, the entry with the greatest length supplies the port.
- R4: When the longest matching length is shared by several valid entries, the entry with the lowest table index supplies the port.
- R5: When no valid entry matches, the answer has `res_hit` = 0 and `res_port` = 0.
- R6: Reset marks every entry invalid. An entry written with `wr_vld` = 0 never matches.
- R7: A lookup accepted in the same cycle as a write sees the old table. A lookup accepted in the following cycle or later sees the new entry.
- R8: From the first cycle after reset, `lk_ready` is 1 and one address is accepted per cycle. Each accepted address gives exactly one `res_valid` pulse two cycles later, in order.
- R9: While reset is held, `lk_ready`, `res_valid` and `res_hit` are 0. `res_hit` is never 1 without `res_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write one table entry this cycle |
| wr_idx | input | IDX_W (3) | Index of the entry to write |
| wr_vld | input | 1 | Valid bit stored in the entry |
| wr_pfx | input | 32 | Prefix value |
| wr_len | input | 6 | Prefix length, 0 to 32 |
| wr_port | input | PORT_W (4) | Outgoing port of the entry |
| lk_valid | input | 1 | Destination address is presented |
| lk_addr | input | 32 | Destination address |
| lk_ready | output | 1 | Engine accepts an address this cycle |
| res_valid | output | 1 | Answer is present |
| res_hit | output | 1 | Some valid entry matched |
| res_port | output | PORT_W (4) | Port of the winning entry, 0 on a miss |

## Verification
The in-RTL properties check four things on every cycle: the two-cycle valid latency and ready behaviour, the zero port on a miss, that no hit appears without a result, and that each write lands in the addressed entry. Several behaviours can only be shown by the bench scenarios, because each needs a known table and a known expected port. These are mask coverage at /0, /8, /19, /21, /24 and /32, and longest-length selection among overlapping routes. They also include the lowest-index tie-break, invalidation, and the exact cycle in which a rewritten entry becomes visible.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = $clog2(ADDR_W + 1);

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [LEN_W-1:0]  plen_t;

  // Upper 'len' bits set; len 0 gives an all-zero mask, len >= ADDR_W all ones.
  function automatic addr_t prefix_mask(input plen_t len);
    addr_t ones;
    ones = '1;
    return ~(ones >> len);
  endfunction
endpackage

// File: rtl/lpm_route_table.sv
module lpm_route_table
  import lpm_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int PORT_W  = 4,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic               wr_vld,
  input  addr_t              wr_pfx,
  input  plen_t              wr_len,
  input  logic [PORT_W-1:0]  wr_port,
  output logic [ENTRIES-1:0] ent_vld,
  output addr_t              ent_pfx  [ENTRIES],
  output plen_t              ent_len  [ENTRIES],
  output logic [PORT_W-1:0]  ent_port [ENTRIES]
);

  // Valid bits carry reset; route payload has none, so it can map to plain storage.
  always_ff @(posedge clk) begin
    if (rst) ent_vld <= '0;
    else if (wr_en) ent_vld[wr_idx] <= wr_vld;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      ent_pfx[wr_idx]  <= wr_pfx;
      ent_len[wr_idx]  <= wr_len;
      ent_port[wr_idx] <= wr_port;
    end
  end

  // R7: a write is held in the addressed entry on the next cycle
  assert_write_lands_R7: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (ent_vld[$past(wr_idx)] == $past(wr_vld)) &&
              (ent_pfx[$past(wr_idx)] == $past(wr_pfx)) &&
              (ent_len[$past(wr_idx)] == $past(wr_len)) &&
              (ent_port[$past(wr_idx)] == $past(wr_port)));

  // R6: leaving reset, no entry is valid
  assert_cleared_R6: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ent_vld == '0));

endmodule

// File: rtl/lpm_match_stage.sv
module lpm_match_stage
  import lpm_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int PORT_W  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               take,
  input  addr_t              addr,
  input  logic [ENTRIES-1:0] ent_vld,
  input  addr_t              ent_pfx  [ENTRIES],
  input  plen_t              ent_len  [ENTRIES],
  input  logic [PORT_W-1:0]  ent_port [ENTRIES],
  output logic               s_vld,
  output logic [ENTRIES-1:0] s_match,
  output plen_t              s_len  [ENTRIES],
  output logic [PORT_W-1:0]  s_port [ENTRIES]
);

  logic [ENTRIES-1:0] hit_c;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_c[g] = ent_vld[g] &&
                      (((addr ^ ent_pfx[g]) & prefix_mask(ent_len[g])) == '0);

    // Length and port are captured with the match bit so a later write cannot skew them.
    always_ff @(posedge clk) begin
      s_len[g]  <= ent_len[g];
      s_port[g] <= ent_port[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s_vld   <= 1'b0;
      s_match <= '0;
    end else begin
      s_vld   <= take;
      s_match <= take ? hit_c : '0;
    end
  end

endmodule

// File: rtl/lpm_pick.sv
module lpm_pick
  import lpm_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int PORT_W  = 4
) (
  input  logic [ENTRIES-1:0] match,
  input  plen_t              len  [ENTRIES],
  input  logic [PORT_W-1:0]  port [ENTRIES],
  output logic               hit,
  output logic [PORT_W-1:0]  win_port
);

  plen_t best;

  // Ascending scan with strict '>' keeps the lowest index on equal lengths.
  always_comb begin
    hit      = 1'b0;
    best     = '0;
    win_port = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i] && (!hit || len[i] > best)) begin
        hit      = 1'b1;
        best     = len[i];
        win_port = port[i];
      end
    end
  end

endmodule

// File: rtl/lpm_lookup_engine.sv
module lpm_lookup_engine
  import lpm_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int PORT_W  = 4,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_vld,
  input  logic [31:0]       wr_pfx,
  input  logic [5:0]        wr_len,
  input  logic [PORT_W-1:0] wr_port,
  input  logic              lk_valid,
  input  logic [31:0]       lk_addr,
  output logic              lk_ready,
  output logic              res_valid,
  output logic              res_hit,
  output logic [PORT_W-1:0] res_port
);

  logic [ENTRIES-1:0] ent_vld;
  addr_t              ent_pfx  [ENTRIES];
  plen_t              ent_len  [ENTRIES];
  logic [PORT_W-1:0]  ent_port [ENTRIES];

  logic               s_vld;
  logic [ENTRIES-1:0] s_match;
  plen_t              s_len  [ENTRIES];
  logic [PORT_W-1:0]  s_port [ENTRIES];

  logic               pick_hit;
  logic [PORT_W-1:0]  pick_port;

  always_ff @(posedge clk) begin
    if (rst) lk_ready <= 1'b0;
    else     lk_ready <= 1'b1;
  end

  lpm_route_table #(.ENTRIES(ENTRIES), .PORT_W(PORT_W)) u_table (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_vld(wr_vld),
    .wr_pfx(wr_pfx), .wr_len(wr_len), .wr_port(wr_port),
    .ent_vld(ent_vld), .ent_pfx(ent_pfx), .ent_len(ent_len), .ent_port(ent_port)
  );

  lpm_match_stage #(.ENTRIES(ENTRIES), .PORT_W(PORT_W)) u_match (
    .clk(clk), .rst(rst), .take(lk_valid && lk_ready), .addr(lk_addr),
    .ent_vld(ent_vld), .ent_pfx(ent_pfx), .ent_len(ent_len), .ent_port(ent_port),
    .s_vld(s_vld), .s_match(s_match), .s_len(s_len), .s_port(s_port)
  );

  lpm_pick #(.ENTRIES(ENTRIES), .PORT_W(PORT_W)) u_pick (
    .match(s_match), .len(s_len), .port(s_port),
    .hit(pick_hit), .win_port(pick_port)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_port  <= '0;
    end else begin
      res_valid <= s_vld;
      res_hit   <= s_vld && pick_hit;
      res_port  <= (s_vld && pick_hit) ? pick_port : '0;
    end
  end

  // R8: one answer per accepted address, two cycles later
  assert_latency_R8: assert property (@(posedge clk) disable iff (rst)
    res_valid == $past(lk_valid && lk_ready, 2));

  // R8: ready from the first cycle after reset
  assert_ready_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> lk_ready);

  // R5: a miss reports port zero
  assert_miss_port_R5: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_hit) |-> (res_port == '0));

  // R9: no hit flag without an answer
  assert_hit_needs_valid_R9: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> !res_hit);

endmodule

// File: tb/lpm_lookup_engine_tb.sv
module lpm_lookup_engine_tb;
  localparam int ENTRIES = 8;
  localparam int PORT_W  = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic [2:0]        wr_idx = '0;
  logic              wr_vld = 1'b0;
  logic [31:0]       wr_pfx = '0;
  logic [5:0]        wr_len = '0;
  logic [PORT_W-1:0] wr_port = '0;
  logic              lk_valid = 1'b0;
  logic [31:0]       lk_addr = '0;
  logic              lk_ready;
  logic              res_valid;
  logic              res_hit;
  logic [PORT_W-1:0] res_port;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  lpm_lookup_engine #(.ENTRIES(ENTRIES), .PORT_W(PORT_W)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_vld(wr_vld),
    .wr_pfx(wr_pfx), .wr_len(wr_len), .wr_port(wr_port),
    .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_ready(lk_ready),
    .res_valid(res_valid), .res_hit(res_hit), .res_port(res_port)
  );

  function automatic logic [31:0] ip(int a, int b, int c, int d);
    return {a[7:0], b[7:0], c[7:0], d[7:0]};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_result(string req, logic eh, logic [PORT_W-1:0] ep);
    check({req, " valid"}, 32'(res_valid), 32'd1);
    check({req, " hit"},   32'(res_hit),   32'(eh));
    check({req, " port"},  32'(res_port),  32'(ep));
  endtask

  task automatic put(int idx, logic v, logic [31:0] pfx, int len, int port);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 3'(idx); wr_vld = v;
    wr_pfx = pfx; wr_len = 6'(len); wr_port = PORT_W'(port);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic lookup(string req, logic [31:0] a, logic eh, logic [PORT_W-1:0] ep);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a;
    @(negedge clk);
    lk_valid = 1'b0;
    check({req, " gap"}, 32'(res_valid), 32'd0);
    @(negedge clk);
    check_result(req, eh, ep);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R9 ready in reset", 32'(lk_ready),  32'd0);
    check("R9 valid in reset", 32'(res_valid), 32'd0);
    check("R9 hit in reset",   32'(res_hit),   32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R8 ready after reset", 32'(lk_ready), 32'd1);
    lookup("R6 empty table miss", ip(65, 1, 2, 3), 1'b0, '0);
  endtask

  task automatic t_overlap();
    put(0, 1'b1, ip(65, 0, 0, 0), 8, 3);
    put(1, 1'b1, ip(128, 9, 0, 0), 16, 1);
    put(2, 1'b1, ip(142, 12, 0, 0), 19, 7);
    put(3, 1'b1, ip(128, 9, 16, 0), 21, 5);
    put(4, 1'b1, ip(128, 9, 176, 0), 24, 9);
    lookup("R1 /8 low edge",    ip(65, 0, 0, 0),      1'b1, 4'd3);
    lookup("R1 /8 high edge",   ip(65, 255, 255, 255), 1'b1, 4'd3);
    lookup("R5 outside /8",     ip(66, 0, 0, 0),      1'b0, 4'd0);
    lookup("R3 /21 over /16",   ip(128, 9, 16, 14),   1'b1, 4'd5);
    lookup("R3 /24 over /16",   ip(128, 9, 176, 7),   1'b1, 4'd9);
    lookup("R3 only /16",       ip(128, 9, 200, 1),   1'b1, 4'd1);
    lookup("R1 /19 top",        ip(142, 12, 31, 255), 1'b1, 4'd7);
    lookup("R5 past /19",       ip(142, 12, 32, 0),   1'b0, 4'd0);
  endtask

  task automatic t_host_route();
    put(6, 1'b1, ip(128, 9, 176, 7), 32, 2);
    lookup("R1 /32 exact",      ip(128, 9, 176, 7), 1'b1, 4'd2);
    lookup("R1 /32 neighbour",  ip(128, 9, 176, 8), 1'b1, 4'd9);
  endtask

  task automatic t_tie_and_invalid();
    put(5, 1'b1, ip(66, 0, 0, 0), 8, 11);
    put(6, 1'b1, ip(66, 0, 0, 0), 8, 12);
    lookup("R4 lower index wins", ip(66, 1, 2, 3), 1'b1, 4'd11);
    put(5, 1'b0, ip(66, 0, 0, 0), 8, 11);
    lookup("R6 invalid skipped",  ip(66, 1, 2, 3), 1'b1, 4'd12);
    put(6, 1'b0, ip(66, 0, 0, 0), 8, 12);
    lookup("R6 both invalid",     ip(66, 1, 2, 3), 1'b0, 4'd0);
  endtask

  task automatic t_default();
    put(7, 1'b1, 32'h0, 0, 15);
    lookup("R2 default catches",   ip(10, 0, 0, 1),   1'b1, 4'd15);
    lookup("R3 specific over /0",  ip(128, 9, 16, 14), 1'b1, 4'd5);
  endtask

  // Write and lookup in the same cycle, then lookup again the cycle after.
  task automatic t_write_timing();
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 3'd7; wr_vld = 1'b1;
    wr_pfx = 32'h0; wr_len = 6'd0; wr_port = 4'd14;
    lk_valid = 1'b1; lk_addr = ip(10, 0, 0, 1);
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
    lk_valid = 1'b0;
    check_result("R7 same cycle sees old", 1'b1, 4'd15);
    @(negedge clk);
    check_result("R7 next cycle sees new", 1'b1, 4'd14);
  endtask

  // Back-to-back stream: one address per cycle, answers in order two cycles later.
  task automatic t_stream();
    logic [31:0]       a  [6];
    logic              eh [6];
    logic [PORT_W-1:0] ep [6];
    a[0] = ip(65, 7, 7, 7);     eh[0] = 1'b1; ep[0] = 4'd3;
    a[1] = ip(128, 9, 16, 14);  eh[1] = 1'b1; ep[1] = 4'd5;
    a[2] = ip(200, 1, 1, 1);    eh[2] = 1'b1; ep[2] = 4'd14;
    a[3] = ip(128, 9, 176, 7);  eh[3] = 1'b1; ep[3] = 4'd9;
    a[4] = ip(142, 12, 5, 5);   eh[4] = 1'b1; ep[4] = 4'd7;
    a[5] = ip(128, 9, 99, 1);   eh[5] = 1'b1; ep[5] = 4'd1;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      if (c >= 2) check_result("R8 stream", eh[c-2], ep[c-2]);
      if (c < 6) begin
        check("R8 ready in stream", 32'(lk_ready), 32'd1);
        lk_valid = 1'b1; lk_addr = a[c];
      end else begin
        lk_valid = 1'b0;
      end
    end
    @(negedge clk);
    check("R8 no extra result", 32'(res_valid), 32'd0);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    t_reset();
    t_overlap();
    t_host_route();
    t_tie_and_invalid();
    t_default();
    t_write_timing();
    t_stream();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule